// File: doc/BRIEF.md
# Continuous Memory Fill and Read-Back Pattern Generator

This block exercises a small register-file memory at full speed using nothing but a fast test clock. A row counter steps through every row. An 8-bit rotating pattern supplies the 4-bit write nibble. Two preloaded 2-bit latches pick one of sixteen nibble targets: the block and the nibble within that block. In write mode the generator issues one half-period write strobe per clock, so a whole target fills in 32 cycles. The rotator length divides the row count, so a second pass writes the same data into each row.

In read mode the same address sequence is replayed. One of the four returned data bits is captured half a clock period after each address change and driven to a scope pin. If the memory is too slow, the wrong value appears on the scope. A sync pin pulses on every address rollover so that an oscilloscope can trigger on it.

The write/read choice comes from two slow, asynchronous pins, the scan clock and the scan-mode pin. Their level at start-up sets the mode. While a run is in progress, read mode can only be reached through a fixed handshake, so a slow edge can never produce a runt write strobe.

Top module: `cmt_pattern_gen`

## Requirements
- R1: After reset, mem_we, sync_out and scope_out are 0, and mem_row, mem_blk and mem_nib are 0.
- R2: With run_en low, a high load_en at a rising edge loads the row counter, the rotator, mem_blk and mem_nib from the load ports. With run_en high, load_en is ignored: the row sequence and mem_blk/mem_nib continue unchanged.
- R3: While run_en is high, the row counter increments by one modulo 32 on each rising edge. mem_row takes the counter value at the following falling edge. The first row driven after start is the preloaded row.
- R4: mem_wdata is bits [3:0] of the rotator, latched together with mem_row. The rotator rotates left by one bit per row step. Row start+k therefore receives bits [3:0] of the preload rotated left by k mod 8, on every pass.
- R5: In write mode, mem_we is high during the high half of every clock period of the run and low during the low half.
- R6: sync_out is high for exactly the clock period that follows the rising edge at which the counter wraps from 31 to 0.
- R7: scope_sel chooses which mem_rdata bit is captured: 0 selects bit 0, up to 3, which selects bit 3.
- R8: In read mode, the selected bit is captured at each rising edge, half a period after mem_row changed at the previous falling edge. scope_out holds that value until the next rising edge.
- R9: While run_en is low, the mode follows the synchronized scan clock pin: low gives write, high gives read. The run starts in that mode. Read mode produces no write strobes.
- R10: During a write run, read mode is entered only after this sequence: scan_mode_pin high, then scan_clk_pin high, then scan_mode_pin low. Write strobes stop while scan_mode_pin is high. A rising scan clock on its own does not change the mode.
- R11: With run_en low, mem_row and scope_out hold and mem_we stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hs_clk | input | 1 | High-speed test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Generator runs while high |
| load_en | input | 1 | Parallel preload strobe, used only while idle |
| load_row | input | 5 | Preload value for the row counter |
| load_rot | input | 8 | Preload value for the rotator |
| load_blk | input | 2 | Preload value for the block select |
| load_nib | input | 2 | Preload value for the nibble select |
| scan_clk_pin | input | 1 | Slow asynchronous scan clock pin |
| scan_mode_pin | input | 1 | Slow asynchronous scan-mode pin |
| scope_sel | input | 2 | Read data bit routed to the scope |
| mem_rdata | input | 4 | Read nibble from the memory |
| mem_row | output | 5 | Row address to the memory |
| mem_blk | output | 2 | Block select to the memory |
| mem_nib | output | 2 | Nibble select to the memory |
| mem_wdata | output | 4 | Write nibble to the memory |
| mem_we | output | 1 | Half-period write strobe |
| scope_out | output | 1 | Sampled read bit |
| sync_out | output | 1 | Rollover marker |

## Verification
Two events are driven into the same cycle. A preload request is raised during a read run so that it meets the rising edge at which the counter wraps from 31 to 0. The bench confirms that the sync pulse still appears, that the row sequence continues with 0 and 1, and that the block and nibble selects keep their values. Separately, the mode handshake is performed while write strobes are running. The bench checks that strobes stop as soon as the scan-mode pin is seen high, and that every later scope sample matches the nibble computed for the row on mem_row.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  typedef enum logic [1:0] {
    M_WRITE = 2'd0,
    M_ARMED = 2'd1,
    M_CLKHI = 2'd2,
    M_READ  = 2'd3
  } mode_e;

  localparam int DEF_ROW_W  = 5;
  localparam int DEF_ROT_W  = 8;
  localparam int DEF_DATA_W = 4;
  localparam int DEF_SEL_W  = 2;
endpackage

// File: rtl/cmt_seq_core.sv
`timescale 1ns/1ps
module cmt_seq_core #(
  parameter int ROW_W  = 5,
  parameter int ROT_W  = 8,
  parameter int DATA_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              load_en,
  input  logic [ROW_W-1:0]  load_row,
  input  logic [ROT_W-1:0]  load_rot,
  input  logic [SEL_W-1:0]  load_blk,
  input  logic [SEL_W-1:0]  load_nib,
  output logic [ROW_W-1:0]  row_cnt,
  output logic [DATA_W-1:0] wr_nib,
  output logic [SEL_W-1:0]  blk_q,
  output logic [SEL_W-1:0]  nib_q,
  output logic              sync_q
);
  localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

  function automatic logic [ROW_W-1:0] row_after(input logic [ROW_W-1:0] r);
    return r + ROW_W'(1);
  endfunction

  function automatic logic [ROT_W-1:0] rot_after(input logic [ROT_W-1:0] v);
    return {v[ROT_W-2:0], v[ROT_W-1]};
  endfunction

  logic [ROT_W-1:0] rot;
  logic             at_last;     // counter sits on the final row
  logic             load_take;   // preload accepted this edge

  assign at_last   = (row_cnt == LAST_ROW);
  assign load_take = load_en && !run_en;
  assign wr_nib    = rot[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt <= '0;
      rot     <= '0;
      blk_q   <= '0;
      nib_q   <= '0;
      sync_q  <= 1'b0;
    end else if (run_en) begin
      row_cnt <= row_after(row_cnt);
      rot     <= rot_after(rot);
      sync_q  <= at_last;
    end else begin
      sync_q <= 1'b0;
      if (load_take) begin
        row_cnt <= load_row;
        rot     <= load_rot;
        blk_q   <= load_blk;
        nib_q   <= load_nib;
      end
    end
  end

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (ROW_W'(row_cnt - $past(row_cnt)) == ROW_W'(1)));

  p_rot_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($countones(rot) == $countones($past(rot))));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_en) |=> ($stable(row_cnt) && $stable(rot)));

  p_target_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(blk_q) && $stable(nib_q)));

  p_sync_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (row_cnt == '0));
endmodule

// File: rtl/cmt_mode_ctrl.sv
`timescale 1ns/1ps
module cmt_mode_ctrl
  import cmt_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic scan_clk_pin,
  input  logic scan_mode_pin,
  output logic wr_ok,
  output logic rd_ok
);
  logic [SYNC_N-1:0][1:0] stg;
  logic  sclk_s, smode_s;
  mode_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      for (int k = SYNC_N - 1; k > 0; k--) stg[k] <= stg[k-1];
      stg[0] <= {scan_mode_pin, scan_clk_pin};
    end
  end

  assign sclk_s  = stg[SYNC_N-1][0];
  assign smode_s = stg[SYNC_N-1][1];

  always_comb begin
    nxt = state;
    if (!run_en) begin
      nxt = sclk_s ? M_READ : M_WRITE;
    end else begin
      case (state)
        M_WRITE: if (smode_s) nxt = M_ARMED;
        M_ARMED: if (!smode_s) nxt = M_WRITE;
                 else if (sclk_s) nxt = M_CLKHI;
        M_CLKHI: if (!smode_s) nxt = M_READ;
        default: nxt = M_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= M_WRITE;
    else        state <= nxt;
  end

  assign wr_ok = run_en && (state == M_WRITE);
  assign rd_ok = run_en && (state == M_READ);

  p_no_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && state == M_WRITE) |=> (state != M_READ));

  p_read_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && state == M_READ && run_en) |=> (state == M_READ || !$past(run_en)));
endmodule

// File: rtl/cmt_addr_stage.sv
`timescale 1ns/1ps
module cmt_addr_stage #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wr_ok,
  output logic [ROW_W-1:0]  mem_row,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);
  logic we_arm;   // strobe armed for the coming high phase

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_row   <= '0;
      mem_wdata <= '0;
      we_arm    <= 1'b0;
    end else begin
      mem_row   <= row_in;
      mem_wdata <= data_in;
      we_arm    <= wr_ok;
    end
  end

  assign mem_we = we_arm & clk;

  p_we_only_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we_arm |-> wr_ok);
endmodule

// File: rtl/cmt_scope_sel.sv
`timescale 1ns/1ps
module cmt_scope_sel #(
  parameter int DATA_W = 4,
  localparam int SSEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ok,
  input  logic [SSEL_W-1:0] sel,
  input  logic [DATA_W-1:0] rdata,
  output logic              scope_q
);
  logic [DATA_W-1:0] pick;
  logic              picked;

  for (genvar k = 0; k < DATA_W; k++) begin : g_pick
    assign pick[k] = rdata[k] && (sel == SSEL_W'(k));
  end
  assign picked = |pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     scope_q <= 1'b0;
    else if (rd_ok) scope_q <= picked;
  end

  p_scope_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(scope_q));
endmodule

// File: rtl/cmt_pattern_gen.sv
`timescale 1ns/1ps
module cmt_pattern_gen #(
  parameter int ROW_W  = cmt_pkg::DEF_ROW_W,
  parameter int ROT_W  = cmt_pkg::DEF_ROT_W,
  parameter int DATA_W = cmt_pkg::DEF_DATA_W,
  parameter int SEL_W  = cmt_pkg::DEF_SEL_W,
  parameter int SYNC_N = 2,
  localparam int SSEL_W = $clog2(DATA_W)
) (
  input  logic              hs_clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              load_en,
  input  logic [ROW_W-1:0]  load_row,
  input  logic [ROT_W-1:0]  load_rot,
  input  logic [SEL_W-1:0]  load_blk,
  input  logic [SEL_W-1:0]  load_nib,
  input  logic              scan_clk_pin,
  input  logic              scan_mode_pin,
  input  logic [SSEL_W-1:0] scope_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ROW_W-1:0]  mem_row,
  output logic [SEL_W-1:0]  mem_blk,
  output logic [SEL_W-1:0]  mem_nib,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              scope_out,
  output logic              sync_out
);
  logic [ROW_W-1:0]  row_cnt;
  logic [DATA_W-1:0] wr_nib;
  logic              wr_ok, rd_ok;

  cmt_seq_core #(.ROW_W(ROW_W), .ROT_W(ROT_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_seq (
    .clk(hs_clk), .rst_n(rst_n), .run_en(run_en), .load_en(load_en),
    .load_row(load_row), .load_rot(load_rot), .load_blk(load_blk), .load_nib(load_nib),
    .row_cnt(row_cnt), .wr_nib(wr_nib), .blk_q(mem_blk), .nib_q(mem_nib), .sync_q(sync_out)
  );

  cmt_mode_ctrl #(.SYNC_N(SYNC_N)) u_mode (
    .clk(hs_clk), .rst_n(rst_n), .run_en(run_en),
    .scan_clk_pin(scan_clk_pin), .scan_mode_pin(scan_mode_pin),
    .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  cmt_addr_stage #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_addr (
    .clk(hs_clk), .rst_n(rst_n), .row_in(row_cnt), .data_in(wr_nib), .wr_ok(wr_ok),
    .mem_row(mem_row), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  cmt_scope_sel #(.DATA_W(DATA_W)) u_scope (
    .clk(hs_clk), .rst_n(rst_n), .rd_ok(rd_ok), .sel(scope_sel),
    .rdata(mem_rdata), .scope_q(scope_out)
  );
endmodule

// File: tb/cmt_pattern_gen_test.sv
`timescale 1ns/1ps
module cmt_pattern_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, load_en = 1'b0;
  logic [4:0] load_row = '0;
  logic [7:0] load_rot = '0;
  logic [1:0] load_blk = '0, load_nib = '0;
  logic       scan_clk_pin = 1'b0, scan_mode_pin = 1'b0;
  logic [1:0] scope_sel = '0;
  logic [3:0] mem_rdata;
  logic [4:0] mem_row;
  logic [1:0] mem_blk, mem_nib;
  logic [3:0] mem_wdata;
  logic       mem_we, scope_out, sync_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int sel_prev = 0;

  always #10 clk = ~clk;

  cmt_pattern_gen uut (
    .hs_clk(clk), .rst_n(rst_n), .run_en(run_en), .load_en(load_en),
    .load_row(load_row), .load_rot(load_rot), .load_blk(load_blk), .load_nib(load_nib),
    .scan_clk_pin(scan_clk_pin), .scan_mode_pin(scan_mode_pin), .scope_sel(scope_sel),
    .mem_rdata(mem_rdata), .mem_row(mem_row), .mem_blk(mem_blk), .mem_nib(mem_nib),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .scope_out(scope_out), .sync_out(sync_out)
  );

  // memory model: 4 blocks x 4 nibbles x 32 rows
  logic [3:0] mem [512];
  initial for (int a = 0; a < 512; a++) mem[a] = 4'h0;
  always @(posedge mem_we) mem[{mem_blk, mem_nib, mem_row}] = mem_wdata;
  assign mem_rdata = mem[{mem_blk, mem_nib, mem_row}];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rotl8(input int x, input int k);
    int v = x & 255;
    for (int j = 0; j < k; j++) v = ((v * 2) & 255) | (v / 128);
    return v;
  endfunction

  function automatic int seed_of(input int t);
    return (t * 16) + (15 - t);
  endfunction

  function automatic int start_of(input int t);
    return ((t / 4) * 5 + (t % 4) * 3) % 32;
  endfunction

  function automatic int exp_nib(input int t, input int row);
    int k = (row - start_of(t) + 32) % 32;
    return rotl8(seed_of(t), k % 8) % 16;
  endfunction

  task automatic preload(input int t, input int row);
    @(posedge clk); #3;
    load_en = 1; load_row = 5'(row); load_rot = 8'(seed_of(t));
    load_blk = 2'(t / 4); load_nib = 2'(t % 4);
    @(posedge clk); #3;
    load_en = 0;
  endtask

  task automatic start_run; @(posedge clk); #3; run_en = 1; endtask
  task automatic stop_run;  @(posedge clk); #3; run_en = 0; endtask

  task automatic fill(input int t, input bit keep);
    int s = start_of(t);
    preload(t, s);
    start_run();
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #5;
      chk("R5 strobe high phase", int'(mem_we), 1);
      chk("R3 row sequence", int'(mem_row), (s + i) % 32);
      chk("R4 write nibble", int'(mem_wdata), exp_nib(t, (s + i) % 32));
      chk("R6 sync on wrap", int'(sync_out), ((s + i) % 32 == 31) ? 1 : 0);
      chk("R2 block latch", int'(mem_blk), t / 4);
      #10;
      chk("R5 strobe low phase", int'(mem_we), 0);
    end
    if (!keep) stop_run();
  endtask

  task automatic read_check(input int t, input int cycles, input int r0, input int conflict_at);
    int held;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #5;
      if (r0 >= 0) chk("R3 row sequence in read", int'(mem_row), (r0 + i) % 32);
      chk("R7 R8 scope sample", int'(scope_out), (exp_nib(t, int'(mem_row)) >> sel_prev) & 1);
      chk("R10 no strobe in read", int'(mem_we), 0);
      chk("R6 sync in read", int'(sync_out), (mem_row == 5'd31) ? 1 : 0);
      chk("R2 block kept", int'(mem_blk), t / 4);
      chk("R2 nibble kept", int'(mem_nib), t % 4);
      held = int'(scope_out);
      #10;
      chk("R8 scope holds in low phase", int'(scope_out), held);
      load_en = (i == conflict_at) ? 1'b1 : 1'b0;
      if (i == conflict_at) begin
        load_row = 5'd7; load_blk = 2'(3 - t / 4); load_nib = 2'(3 - t % 4);
      end
      sel_prev = (i * 3 + t) % 4;
      scope_sel = 2'(sel_prev);
    end
    load_en = 0;
  endtask

  initial begin
    int r_idle;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(posedge clk); #5;
    chk("R1 reset strobe", int'(mem_we), 0);
    chk("R1 reset sync", int'(sync_out), 0);
    chk("R1 reset scope", int'(scope_out), 0);
    chk("R1 reset row", int'(mem_row), 0);
    chk("R1 reset block", int'(mem_blk), 0);
    chk("R1 reset nibble", int'(mem_nib), 0);

    // fill all sixteen targets in write mode (R9 low scan clock at start)
    for (int t = 0; t < 15; t++) fill(t, 0);
    fill(15, 1);

    // handshake during a write run
    @(posedge clk); #3 scan_mode_pin = 1;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R10 strobes stop with scan mode high", int'(mem_we), 0);
    end
    #3 scan_clk_pin = 1;
    repeat (5) @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk("R10 no strobe mid handshake", int'(mem_we), 0);
    end
    #3 scan_mode_pin = 0;
    repeat (6) @(posedge clk);
    #13;
    read_check(15, 40, -1, -1);
    stop_run();

    // scan clock left high: runs start directly in read mode (R9)
    for (int t = 0; t < 15; t++) begin
      int r0 = (t * 7) % 32;
      preload(t, r0);
      start_run();
      read_check(t, 34, r0, (t == 5) ? (62 - r0) % 32 : -1);
      stop_run();
    end

    // idle hold (R11)
    scan_clk_pin = 0;
    @(posedge clk); #5;
    r_idle = int'(mem_row);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R11 row holds while idle", int'(mem_row), r_idle);
      chk("R11 no strobe while idle", int'(mem_we), 0);
    end
    // low scan clock at start gives write mode again (R9)
    start_run();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #5;
      chk("R9 write mode after low scan clock", int'(mem_we), 1);
    end
    stop_run();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule